// File: doc/BRIEF.md
# Retention Integrity Checksum Checker

This block confirms that register state held in retention flops survives a power-down and power-up sequence. A SAVE event starts a pass over the sleep-scan chain. The block enables the chain for exactly one full rotation and folds every bit that leaves the chain into a serial CRC-32. It then offers the result as a word on a memory write port, so the checksum can be stored off-domain before the rail drops. A RESTORE event runs the same pass over the restored contents and stores the second checksum at the next word address. It then compares this checksum with the saved one. A difference sets a sticky corruption flag.

During a pass, each bit that leaves the chain is fed straight back into the chain's input. The chain therefore ends a pass holding exactly what it held before, and the check leaves the contents untouched. The block is only meant to run around sleep transitions, while the domain is otherwise quiet. It is not a real-time monitor. The chain shifts on the block clock in every cycle that `scan_en` is high.

The memory port is a valid/ready stream with these rules. `mem_valid` rises together with a word. While `mem_valid` is high and `mem_ready` is low, address and data hold steady. The word is taken on the first clock edge on which both are high, and `mem_valid` falls after that edge. With `mem_ready` held high, each word is a single-cycle strobe. Back-pressure only lengthens the write phase and does not change the checksum.

Top module: `retcheck_top`

## Requirements
- R1: After reset, `scan_en`, `mem_valid`, `done`, `busy` and `corrupt` are all 0.
- R2: A SAVE or RESTORE event sampled while idle makes `scan_en` high for exactly CHAIN_LEN consecutive cycles, beginning in the cycle after the event. `done` is high for one cycle, in the cycle right after the last shift, with `scan_en` low.
- R3: The checksum is a CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF, taken over the bits of `scan_so` in shift order. For each bit b, the update is f = c[31]^b, then c = {c[30:0],0} ^ (f ? poly : 0). No reflection and no final inversion are applied.
- R4: After a SAVE pass, the checksum is written at address BASE_ADDR. After a RESTORE pass, it is written at BASE_ADDR+1. Each pass produces exactly one accepted write.
- R5: Address and data stay stable while `mem_valid` is high and `mem_ready` is low.
- R6: While `scan_en` is high, `scan_si` equals `scan_so`, so a pass leaves the chain contents unchanged.
- R7: When a RESTORE write is accepted, `corrupt` is set if a SAVE checksum is held and differs from the RESTORE checksum. It is not set when the two checksums match.
- R8: `corrupt` stays set until `clr_corrupt` is sampled high, and it clears on that edge.
- R9: Events that arrive while busy are ignored. If both events arrive together while idle, SAVE is taken. A RESTORE with no SAVE since reset still writes its word but does not compare.
- R10: `busy` is high from the cycle after the accepted event up to the edge that accepts the write, and low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_evt | input | 1 | State has been saved into retention flops |
| restore_evt | input | 1 | State has been restored from retention flops |
| clr_corrupt | input | 1 | Clears the sticky corruption flag |
| scan_en | output | 1 | Chain shifts on this clock edge |
| scan_si | output | 1 | Bit into the chain input |
| scan_so | input | 1 | Bit from the chain output |
| mem_valid | output | 1 | Checksum word offered |
| mem_ready | input | 1 | Memory accepts the word |
| mem_addr | output | ADDR_W | Word address |
| mem_data | output | 32 | Checksum word |
| done | output | 1 | One-cycle pulse when a scan pass ends |
| busy | output | 1 | A pass or its write is in progress |
| corrupt | output | 1 | Sticky checksum mismatch flag |

## Verification
The bench builds the block with CHAIN_LEN = 37, ADDR_W = 6 and BASE_ADDR = 0x2A. The chain length is odd and not a power of two, so an off-by-one in the shift count shows up directly as a wrong `done` cycle and a wrong CRC. The base address sits away from zero, so a missing offset for the RESTORE word is exposed. The short chain keeps each pass to a few dozen cycles. Many save/restore pairs can then be run with random contents, random stalls and single-bit corruption injected between the two passes.

// File: rtl/retcheck_pkg.sv
package retcheck_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SCAN  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;

  typedef enum logic {
    OP_SAVE    = 1'b0,
    OP_RESTORE = 1'b1
  } op_t;
endpackage

// File: rtl/retcheck_crc.sv
module retcheck_crc #(
  parameter int W = 32,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;
  logic         fb;

  always_comb begin
    fb    = crc_q[W-1] ^ din;
    crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= SEED;
    else if (init)  crc_q <= SEED;
    else if (shift) crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R3
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !shift) |=> $stable(crc_q));
endmodule

// File: rtl/retcheck_seq.sv
module retcheck_seq
  import retcheck_pkg::*;
#(
  parameter int CHAIN_LEN = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   save_evt,
  input  logic   restore_evt,
  input  logic   wr_done,
  output phase_t phase,
  output op_t    op,
  output logic   shift,
  output logic   crc_init,
  output logic   done
);
  localparam int CNT_W = $clog2(CHAIN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

  phase_t           phase_q;
  op_t              op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             start;

  assign start    = (phase_q == PH_IDLE) && (save_evt || restore_evt);
  assign crc_init = start;
  assign shift    = (phase_q == PH_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_SAVE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_SCAN;
            op_q    <= save_evt ? OP_SAVE : OP_RESTORE;
            cnt_q   <= '0;
          end
        end
        PH_SCAN: begin
          if (cnt_q == LAST) begin
            phase_q <= PH_WRITE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_WRITE: begin
          if (wr_done) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase = phase_q;
  assign op    = op_q;
  assign done  = done_q;

  // checker: count shift cycles since the last start
  logic [CNT_W:0] shifts_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shifts_seen <= '0;
    else if (start) shifts_seen <= '0;
    else if (shift) shifts_seen <= shifts_seen + 1'b1;
  end

  // R2
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (shifts_seen == (CNT_W+1)'(CHAIN_LEN)) && !shift);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  shift_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift) |-> done);
endmodule

// File: rtl/retcheck_wr.sv
module retcheck_wr
  import retcheck_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  op_t               op,
  input  logic [W-1:0]      crc,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [W-1:0]      mem_data,
  output logic              accept
);
  assign mem_valid = (phase == PH_WRITE);
  assign mem_addr  = BASE_ADDR + ADDR_W'(op == OP_RESTORE);
  assign mem_data  = crc;
  assign accept    = mem_valid && mem_ready;

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  // R4
  wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !mem_valid);
endmodule

// File: rtl/retcheck_top.sv
module retcheck_top
  import retcheck_pkg::*;
#(
  parameter int CHAIN_LEN = 64,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_evt,
  input  logic              restore_evt,
  input  logic              clr_corrupt,
  output logic              scan_en,
  output logic              scan_si,
  input  logic              scan_so,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CRC_W-1:0]  mem_data,
  output logic              done,
  output logic              busy,
  output logic              corrupt
);
  phase_t           phase;
  op_t              op;
  logic             shift;
  logic             crc_init;
  logic             accept;
  logic [CRC_W-1:0] crc;
  logic [CRC_W-1:0] saved_q;
  logic             have_save_q;
  logic             corrupt_q;
  logic             mismatch;

  retcheck_seq #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .save_evt(save_evt), .restore_evt(restore_evt),
    .wr_done(accept), .phase(phase), .op(op), .shift(shift),
    .crc_init(crc_init), .done(done)
  );

  retcheck_crc #(.W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .shift(shift),
    .din(scan_so), .crc(crc)
  );

  retcheck_wr #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .W(CRC_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .phase(phase), .op(op), .crc(crc),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .accept(accept)
  );

  assign scan_en = shift;
  assign scan_si = shift ? scan_so : 1'b0;
  assign busy    = (phase != PH_IDLE);

  assign mismatch = accept && (op == OP_RESTORE) && have_save_q && (crc != saved_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_q     <= '0;
      have_save_q <= 1'b0;
      corrupt_q   <= 1'b0;
    end else begin
      if (accept && op == OP_SAVE) begin
        saved_q     <= crc;
        have_save_q <= 1'b1;
      end
      if (mismatch)         corrupt_q <= 1'b1;
      else if (clr_corrupt) corrupt_q <= 1'b0;
    end
  end

  assign corrupt = corrupt_q;

  // R8
  corrupt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (corrupt && !clr_corrupt) |=> corrupt);

  // R7
  corrupt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(corrupt) |-> $past(accept) && $past(op == OP_RESTORE));

  // R10
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !save_evt && !restore_evt) |=> !busy);

  // R6
  scan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> !scan_si);
endmodule

// File: tb/sim_retcheck_top.sv
module sim_retcheck_top;
  localparam int L = 37;
  localparam int AW = 6;
  localparam logic [AW-1:0] BASE = 6'h2A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          save_evt = 1'b0, restore_evt = 1'b0, clr_corrupt = 1'b0;
  logic          scan_en, scan_si, scan_so;
  logic          mem_valid, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_data;
  logic          done, busy, corrupt;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  retcheck_top #(.CHAIN_LEN(L), .ADDR_W(AW), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .save_evt(save_evt), .restore_evt(restore_evt),
    .clr_corrupt(clr_corrupt), .scan_en(scan_en), .scan_si(scan_si),
    .scan_so(scan_so), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .done(done), .busy(busy),
    .corrupt(corrupt)
  );

  // scan chain model
  logic [L-1:0] chain = '0;
  logic [L-1:0] load_val = '0;
  logic         load_req = 1'b0;
  assign scan_so = chain[L-1];
  always @(posedge clk) begin
    if (scan_en)       chain <= {chain[L-2:0], scan_si};
    else if (load_req) chain <= load_val;
  end

  function automatic logic [31:0] ref_crc(input logic [L-1:0] c);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = L - 1; i >= 0; i--) begin
      logic f = r[31] ^ c[i];
      r = {r[30:0], 1'b0} ^ (f ? 32'h04C1_1DB7 : 32'h0);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_chain(input logic [L-1:0] v);
    @(negedge clk); load_val = v; load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
  endtask

  // model of the compare state
  logic [31:0] m_saved = '0;
  bit          m_have = 0;
  bit          m_corrupt = 0;

  task automatic run_op(input bit is_restore, input bit stall, input bit poke);
    logic [L-1:0] snap;
    logic [31:0]  exp_crc;
    logic [AW-1:0] waddr;
    logic [31:0]  wdata;
    int n, shifts, donecyc, doneshifts;
    bit first_scan, first_busy, got;
    snap = chain;
    exp_crc = ref_crc(snap);
    @(negedge clk);
    if (is_restore) restore_evt = 1'b1; else save_evt = 1'b1;
    @(negedge clk);
    save_evt = 1'b0; restore_evt = 1'b0;
    n = 0; shifts = 0; donecyc = -1; doneshifts = -1; got = 0;
    first_scan = scan_en; first_busy = busy;
    waddr = '0; wdata = '0;
    while (!got && n < 2000) begin
      mem_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      if (poke && n == 3) begin
        if (is_restore) save_evt = 1'b1; else restore_evt = 1'b1;
      end
      if (poke && n == 4) begin save_evt = 1'b0; restore_evt = 1'b0; end
      if (scan_en) shifts++;
      if (done) begin donecyc = n; doneshifts = shifts; end
      if (mem_valid && mem_ready) begin got = 1; waddr = mem_addr; wdata = mem_data; end
      n++;
      if (!got) @(negedge clk);
    end
    @(negedge clk);
    mem_ready = 1'b0; save_evt = 1'b0; restore_evt = 1'b0;
    check(first_scan == 1'b1, "R2 scan starts next cycle", first_scan, 1);
    check(donecyc == L, "R2 done cycle", donecyc, L);
    check(doneshifts == L && shifts == L, "R2 shift count", shifts, L);
    check(got, "R4 write accepted", got, 1);
    check(waddr == BASE + (is_restore ? 1 : 0), "R4 write address", waddr, BASE + (is_restore ? 1 : 0));
    check(wdata == exp_crc, "R3 checksum", wdata, exp_crc);
    check(chain == snap, "R6 chain unchanged", chain, snap);
    check(first_busy == 1'b1, "R10 busy during pass", first_busy, 1);
    check(busy == 1'b0 && mem_valid == 1'b0, "R10 idle after write", {busy, mem_valid}, 0);
    if (poke)
      check(scan_en == 1'b0, "R9 event while busy ignored", scan_en, 0);
    if (!is_restore) begin
      m_saved = exp_crc; m_have = 1;
    end else if (m_have && exp_crc != m_saved) begin
      m_corrupt = 1;
    end
    check(corrupt == m_corrupt, "R7 corrupt flag", corrupt, m_corrupt);
  endtask

  task automatic clear_flag();
    @(negedge clk); clr_corrupt = 1'b1;
    @(negedge clk); clr_corrupt = 1'b0;
    m_corrupt = 0;
    check(corrupt == 1'b0, "R8 clear", corrupt, 0);
  endtask

  function automatic logic [L-1:0] rand_chain();
    logic [L-1:0] v;
    v = {$urandom, $urandom};
    return v;
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0017);
    repeat (3) @(negedge clk);
    // R1
    check({scan_en, mem_valid, done, busy, corrupt} == 5'b0, "R1 reset outputs",
          {scan_en, mem_valid, done, busy, corrupt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({scan_en, mem_valid, done, busy, corrupt} == 5'b0, "R1 idle after reset",
          {scan_en, mem_valid, done, busy, corrupt}, 0);

    // R9: restore before any save writes but does not compare
    load_chain(rand_chain());
    run_op(1, 0, 0);

    // clean save / restore
    load_chain({L{1'b1}});
    run_op(0, 0, 0);
    run_op(1, 0, 0);

    // corruption: flip one bit between the passes
    load_chain(rand_chain());
    run_op(0, 1, 0);
    load_chain(chain ^ ({{(L-1){1'b0}}, 1'b1} << 17));
    run_op(1, 1, 0);
    check(corrupt == 1'b1, "R7 mismatch sets flag", corrupt, 1);

    // R8: sticky through a clean pair
    run_op(0, 0, 0);
    run_op(1, 0, 0);
    check(corrupt == 1'b1, "R8 flag sticky", corrupt, 1);
    clear_flag();

    // R9: other event during a pass is ignored
    load_chain(rand_chain());
    run_op(0, 0, 1);
    run_op(1, 0, 1);

    // R9: simultaneous events take SAVE
    load_chain(rand_chain());
    @(negedge clk); save_evt = 1'b1; restore_evt = 1'b1;
    @(negedge clk); save_evt = 1'b0; restore_evt = 1'b0;
    mem_ready = 1'b1;
    while (!mem_valid) @(negedge clk);
    check(mem_addr == BASE, "R9 simultaneous events pick save", mem_addr, BASE);
    check(mem_data == ref_crc(chain), "R3 checksum simultaneous", mem_data, ref_crc(chain));
    m_saved = ref_crc(chain); m_have = 1;
    @(negedge clk); mem_ready = 1'b0;

    // random pairs
    for (int it = 0; it < 24; it++) begin
      bit flip;
      load_chain(rand_chain());
      run_op(0, 1, 0);
      flip = ($urandom % 2) == 1;
      if (flip) load_chain(chain ^ ({{(L-1){1'b0}}, 1'b1} << ($urandom % L)));
      run_op(1, 1, 0);
      check(corrupt == flip, "R7 random pair", corrupt, flip);
      if (corrupt) clear_flag();
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule